// File: doc/BRIEF.md
# Critical-Word-First Line Packetizer

This block frames one cache line as an outgoing data message on a valid/ready stream. The requester loads the whole line as a parallel vector of words, together with the index of the word it is waiting for and a field of message metadata. The block then emits a header beat, then the requested word, then every other word of the line in ascending index order with the requested one left out. A last marker flags the final data beat.

A new message is accepted only while the block is idle. A `start_i` pulse with `busy_o` low captures the line, the index and the metadata. From then on the sending side may change those inputs freely. The header carries the requested index, so the receiver can return each word to its slot. Every word leaves exactly once, so a later miss on any word of the line is served once that word has arrived.

Top module: `cwf_packetizer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid_o` and `busy_o` are both low.
- R2: `start_i` is taken only when `busy_o` is low. A `start_i` pulse while busy has no effect on the message in flight or on the beat count.
- R3: The first beat of every message is the header, with `out_hdr_o` high. Its low IDX_W bits hold the requested word index, and the bits above them hold the captured metadata. `out_hdr_o` is low on every other beat.
- R4: The second beat carries the word at the requested index.
- R5: Beats three onward carry the remaining words in ascending index order, skipping the requested index. No word is repeated.
- R6: A message has exactly NUM_WORDS+1 beats. `out_last_o` is high on the final beat only.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the next cycle still shows valid, with the same data and marker values.
- R8: `busy_o` rises in the cycle after an accepted start. It falls, together with `out_valid_o`, in the cycle after the last beat's handshake.
- R9: The line, index and metadata are captured at acceptance. Later changes on `line_i`, `crit_idx_i` or `meta_i` do not alter the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send a line; taken only when idle |
| line_i | input | NUM_WORDS*WORD_W | Cache line, word i at bits [i*WORD_W +: WORD_W] |
| crit_idx_i | input | IDX_W | Index (0-based) of the requested word |
| meta_i | input | WORD_W-IDX_W | Metadata placed above the index in the header |
| busy_o | output | 1 | A message is being sent |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Receiver accepts the beat |
| out_data_o | output | WORD_W | Beat payload |
| out_hdr_o | output | 1 | Beat is the header |
| out_last_o | output | 1 | Beat is the final data word |

## Verification
The assertions assume that the requested index presented with an accepted start is below NUM_WORDS. This holds trivially at the default power-of-two line size, and the bench only ever drives indices 0 to 7. The stimulus also exercises the ignored inputs. In mid-message it pulses start with a different index and rewrites the line and metadata, and the scoreboard must still see only the originally captured message. Back-pressure comes from a pseudo-random ready pattern as well as from always-ready runs, so the stall-hold property is triggered on many beat positions.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } frame_state_e;
endpackage

// File: rtl/cwf_line_store.sv
module cwf_line_store #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 64,
  parameter int IDX_W     = $clog2(NUM_WORDS),
  parameter int META_W    = WORD_W - IDX_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic [NUM_WORDS*WORD_W-1:0] line_i,
  input  logic [IDX_W-1:0]            crit_i,
  input  logic [META_W-1:0]           meta_i,
  input  logic [IDX_W-1:0]            sel_i,
  output logic [WORD_W-1:0]           word_o,
  output logic [IDX_W-1:0]            crit_o,
  output logic [META_W-1:0]           meta_o
);
  logic [WORD_W-1:0] words_q [NUM_WORDS];
  logic [IDX_W-1:0]  crit_q;
  logic [META_W-1:0] meta_q;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q[g] <= '0;
      end else if (load_i) begin
        words_q[g] <= line_i[g*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_q <= '0;
      meta_q <= '0;
    end else if (load_i) begin
      crit_q <= crit_i;
      meta_q <= meta_i;
    end
  end

  assign word_o = words_q[sel_i];
  assign crit_o = crit_q;
  assign meta_o = meta_q;
endmodule

// File: rtl/cwf_order_gen.sv
module cwf_order_gen #(
  parameter int NUM_WORDS = 8,
  parameter int IDX_W     = $clog2(NUM_WORDS),
  parameter int CNT_W     = $clog2(NUM_WORDS + 1)
) (
  input  logic [CNT_W-1:0] beat_i,
  input  logic [IDX_W-1:0] crit_i,
  output logic             is_hdr_o,
  output logic             is_last_o,
  output logic [IDX_W-1:0] word_idx_o
);
  localparam logic [CNT_W-1:0] LAST_BEAT  = CNT_W'(NUM_WORDS);
  localparam logic [CNT_W-1:0] FIRST_REST = CNT_W'(2);

  logic [CNT_W-1:0] crit_ext;
  logic [CNT_W-1:0] rest_pos;
  logic [CNT_W-1:0] pick;

  assign crit_ext = CNT_W'(crit_i);
  assign rest_pos = beat_i - FIRST_REST;

  always_comb begin
    if (beat_i < FIRST_REST) begin
      pick = crit_ext;
    end else if (rest_pos < crit_ext) begin
      pick = rest_pos;
    end else begin
      pick = rest_pos + CNT_W'(1);
    end
  end

  assign is_hdr_o   = (beat_i == '0);
  assign is_last_o  = (beat_i == LAST_BEAT);
  assign word_idx_o = pick[IDX_W-1:0];
endmodule

// File: rtl/cwf_frame_ctrl.sv
module cwf_frame_ctrl #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  input  logic             is_last_i,
  output logic             load_o,
  output logic             active_o,
  output logic [CNT_W-1:0] beat_o
);
  import cwf_pkg::*;

  frame_state_e     state_q, state_d;
  logic [CNT_W-1:0] beat_q, beat_d;
  logic             beat_en;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    beat_en = 1'b0;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_SEND;
          beat_d  = '0;
          beat_en = 1'b1;
        end
      end
      ST_SEND: begin
        if (ready_i) begin
          if (is_last_i) begin
            state_d = ST_IDLE;
          end else begin
            beat_d  = beat_q + CNT_W'(1);
            beat_en = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  assign active_o = (state_q == ST_SEND);
  assign beat_o   = beat_q;
endmodule

// File: rtl/cwf_packetizer.sv
module cwf_packetizer #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 64,
  parameter int IDX_W     = $clog2(NUM_WORDS),
  parameter int META_W    = WORD_W - IDX_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [NUM_WORDS*WORD_W-1:0] line_i,
  input  logic [IDX_W-1:0]            crit_idx_i,
  input  logic [META_W-1:0]           meta_i,
  output logic                        busy_o,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic [WORD_W-1:0]           out_data_o,
  output logic                        out_hdr_o,
  output logic                        out_last_o
);
  localparam int CNT_W = $clog2(NUM_WORDS + 1);

  logic             load;
  logic             active;
  logic [CNT_W-1:0] beat;
  logic             is_hdr;
  logic             is_last;
  logic [IDX_W-1:0] word_idx;
  logic [WORD_W-1:0] word;
  logic [IDX_W-1:0] crit_q;
  logic [META_W-1:0] meta_q;

  cwf_frame_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ready_i   (out_ready_i),
    .is_last_i (is_last),
    .load_o    (load),
    .active_o  (active),
    .beat_o    (beat)
  );

  cwf_order_gen #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_order (
    .beat_i     (beat),
    .crit_i     (crit_q),
    .is_hdr_o   (is_hdr),
    .is_last_o  (is_last),
    .word_idx_o (word_idx)
  );

  cwf_line_store #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W), .META_W(META_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .line_i (line_i),
    .crit_i (crit_idx_i),
    .meta_i (meta_i),
    .sel_i  (word_idx),
    .word_o (word),
    .crit_o (crit_q),
    .meta_o (meta_q)
  );

  assign busy_o      = active;
  assign out_valid_o = active;
  assign out_hdr_o   = active & is_hdr;
  assign out_last_o  = active & is_last;
  assign out_data_o  = is_hdr ? {meta_q, crit_q} : word;
endmodule

// File: rtl/cwf_packetizer_chk.sv
module cwf_packetizer_chk #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 64,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [IDX_W-1:0]  crit_idx_i,
  input logic              busy_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [WORD_W-1:0] out_data_o,
  input logic              out_hdr_o,
  input logic              out_last_o
);
  localparam int CNT_W = $clog2(NUM_WORDS + 1);

  logic [CNT_W-1:0] hs_cnt;
  logic [IDX_W-1:0] crit_seen;
  logic             accept;
  logic             hs;

  assign accept = start_i & ~busy_o;
  assign hs     = out_valid_o & out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_cnt    <= '0;
      crit_seen <= '0;
    end else if (accept) begin
      hs_cnt    <= '0;
      crit_seen <= crit_idx_i;
    end else if (hs) begin
      hs_cnt    <= hs_cnt + CNT_W'(1);
    end
  end

  AST_CRIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (int'(crit_idx_i) < NUM_WORDS)); // R4
  AST_START_OPENS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_o && out_valid_o && out_hdr_o)); // R3
  AST_HDR_CARRIES_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_hdr_o) |-> (out_data_o[IDX_W-1:0] == crit_seen)); // R3
  AST_HDR_ONLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_hdr_o == (hs_cnt == '0))); // R3
  AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_last_o == (hs_cnt == CNT_W'(NUM_WORDS)))); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o) && $stable(out_hdr_o))); // R7
  AST_DONE_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && out_last_o) |=> (!busy_o && !out_valid_o)); // R8
  AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> busy_o); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !(out_ready_i && out_last_o)) |=> busy_o && !out_hdr_o); // R2
endmodule

bind cwf_packetizer cwf_packetizer_chk #(
  .NUM_WORDS(NUM_WORDS),
  .WORD_W   (WORD_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .crit_idx_i  (crit_idx_i),
  .busy_o      (busy_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_hdr_o   (out_hdr_o),
  .out_last_o  (out_last_o)
);

// File: tb/cwf_packetizer_bench.sv
`timescale 1ns/1ps
module cwf_packetizer_bench;
  localparam int NUM_WORDS = 8;
  localparam int WORD_W    = 64;
  localparam int IDX_W     = 3;
  localparam int META_W    = WORD_W - IDX_W;
  localparam int LINE_W    = NUM_WORDS * WORD_W;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              hdr;
    logic              last;
    logic [3:0]        req;
  } beat_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic [LINE_W-1:0] line_i;
  logic [IDX_W-1:0]  crit_idx_i;
  logic [META_W-1:0] meta_i;
  logic              busy_o, out_valid_o, out_ready_i, out_hdr_o, out_last_o;
  logic [WORD_W-1:0] out_data_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  beat_t exp_q[$];

  always #2 clk = ~clk;

  cwf_packetizer #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_cwf_packetizer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_i(line_i),
    .crit_idx_i(crit_idx_i), .meta_i(meta_i), .busy_o(busy_o),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_data_o(out_data_o), .out_hdr_o(out_hdr_o), .out_last_o(out_last_o)
  );

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [WORD_W-1:0] mkword(input int m, input int i);
    return {16'(m), 16'(i), 32'hA5A5_0000 ^ 32'(m * 37 + i)};
  endfunction

  // ready driver
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready_i <= (ready_mode == 0) ? 1'b1 : lfsr[0] | lfsr[3];
  end

  // monitor / scoreboard
  logic              stall_seen = 1'b0;
  logic [WORD_W-1:0] stall_data;
  logic              done_seen = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_seen) begin
        check(!busy_o && !out_valid_o, "R8", "idle after last",
              {62'd0, busy_o, out_valid_o}, '0);
        done_seen = 1'b0;
      end
      if (stall_seen) begin
        check(out_valid_o && out_data_o == stall_data, "R7", "held beat",
              out_data_o, stall_data);
        stall_seen = 1'b0;
      end
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected beat", out_data_o, '0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          check(out_data_o == e.data && out_hdr_o == e.hdr && out_last_o == e.last,
                tag(e.req), "beat", out_data_o, e.data);
          if (e.last) check(out_last_o, "R6", "last marker", {63'd0, out_last_o}, 64'd1);
        end
        if (out_last_o) done_seen = 1'b1;
      end else if (out_valid_o) begin
        stall_seen = 1'b1;
        stall_data = out_data_o;
      end
    end
  end

  task automatic send_msg(input int m, input int crit, input bit disturb);
    beat_t b;
    logic [LINE_W-1:0] ln;
    for (int i = 0; i < NUM_WORDS; i++) ln[i*WORD_W +: WORD_W] = mkword(m, i);
    b.data = {META_W'(m * 1000 + 7), IDX_W'(crit)}; b.hdr = 1; b.last = 0; b.req = 4'd3;
    exp_q.push_back(b);
    b.data = mkword(m, crit); b.hdr = 0; b.req = 4'd4;
    exp_q.push_back(b);
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (i != crit) begin
        b.data = mkword(m, i); b.req = 4'd5; b.last = (i == NUM_WORDS - 1) ||
          (crit == NUM_WORDS - 1 && i == NUM_WORDS - 2);
        exp_q.push_back(b);
      end
    end
    @(negedge clk);
    while (busy_o) @(negedge clk);
    @(posedge clk); #1;
    start_i = 1'b1; line_i = ln; crit_idx_i = IDX_W'(crit); meta_i = META_W'(m * 1000 + 7);
    @(posedge clk); #1;
    start_i = 1'b0;
    if (disturb) begin
      // R2 and R9: new start and changed inputs while busy must not alter output
      @(posedge clk); #1;
      start_i = 1'b1; crit_idx_i = IDX_W'(crit + 3); line_i = ~ln; meta_i = '1;
      @(posedge clk); #1;
      start_i = 1'b0;
      @(posedge clk); #1;
      line_i = '0;
    end
    @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; line_i = '0; crit_idx_i = '0; meta_i = '0;
    out_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid_o && !busy_o, "R1", "reset state", {62'd0, busy_o, out_valid_o}, '0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid_o && !busy_o, "R1", "after reset", {62'd0, busy_o, out_valid_o}, '0);
    send_msg(1, 4, 1'b0);   // R4 R5 the mid-line case
    send_msg(2, 0, 1'b0);   // R5 crit at the bottom
    send_msg(3, 7, 1'b0);   // R6 crit at the top: last is word 6
    send_msg(4, 2, 1'b1);   // R2 R9 disturbance
    ready_mode = 1;
    for (int c = 0; c < NUM_WORDS; c++) send_msg(10 + c, c, c[0]); // R7 back-pressure
    send_msg(30, 5, 1'b1);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6", "all beats delivered", 64'(exp_q.size()), '0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule